// File: doc/BRIEF.md
# Branch Trace History Buffer

The block keeps a short record of program-flow changes for on-chip debug. While tracing is switched on, every taken branch, interrupt or exception reported by the core loads one source/destination address pair into a four-deep history. For a branch, the pair is the address of the branch instruction and the address of its target. For an interrupt or exception, the pair is the return address the core pushed to the stack and the entry address of the handler. The newest pair sits at the head of the history.

Debug software reads the history through a small synchronous register port. It reads the source word of the head entry first and then the destination word. Reading the destination word retires the head entry, so the next older pair moves up. Both words come from one shared read position. A status word reports how many entries are valid. Turning tracing off and back on discards everything captured before.

Top module: `trace_hist_top`

## Requirements
- R1: After reset the control word (offset 0) reads 0, the status word (offset 1) reads 0, and the source (offset 2) and destination (offset 3) words read 0.
- R2: An event strobe is ignored while the enable bit (control bit 0) is 0, and the valid count stays the same.
- R3: For an event with kind 0 (branch), the captured source is `br_src_i` and the captured destination is `br_dst_i`.
- R4: For an event with kind 1 (interrupt or exception), the captured source is `exc_ret_i` and the captured destination is `exc_vec_i`. The branch address inputs are not used.
- R5: The history holds four pairs with the newest at the head. A fifth event while four pairs are held drops the oldest pair.
- R6: A read of offset 2 returns the head source address and leaves the history and the valid count unchanged.
- R7: A read of offset 3 returns the head destination address. At the following clock edge the head entry is removed and the next older pair becomes the head.
- R8: Source and destination reads return 0 when the history is empty. A destination read on an empty history changes nothing.
- R9: The status word holds the number of valid entries (0 to 4) in bits [2:0]. All higher bits read 0.
- R10: A write of 1 to the enable bit while the bit is 0 invalidates all entries. Clearing the bit keeps the entries readable. Writing 1 while the bit is already 1 keeps them.
- R11: When an event and a destination read occur in the same cycle, the capture is applied first and the pop is then applied to the updated history. That read still returns the previous head destination.
- R12: Writes to offsets 1, 2 and 3 have no effect. A write to offset 0 changes only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_vld_i | input | 1 | Single-cycle program-flow event strobe |
| evt_kind_i | input | 1 | 0 = branch, 1 = interrupt or exception |
| br_src_i | input | 32 | Address of the branch instruction |
| br_dst_i | input | 32 | Branch target address |
| exc_ret_i | input | 32 | Return address pushed to the stack for the event |
| exc_vec_i | input | 32 | Handler entry address |
| reg_sel_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_off_i | input | 2 | Word offset: 0 control, 1 status, 2 source, 3 destination |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the access |

## Verification
The bench fills the history past its depth and pops it empty. A design that drops the newest pair instead of the oldest, or that pops in the wrong order, returns the wrong sequence of addresses. It issues repeated source reads to catch a design that advances the queue on the wrong word, and it reads an empty history to catch stale data that was never masked. It toggles the enable bit in each direction separately, because a design that clears on any enable write or on disable loses live entries. It also fires an event and a destination read in the same cycle, with the history partly full and with it full, where a wrong priority leaves the wrong count or the wrong head.

// File: rtl/trace_hist_pkg.sv
package trace_hist_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic {
    EVT_BRANCH = 1'b0,
    EVT_EXCEPT = 1'b1
  } evt_kind_e;

  typedef enum logic [1:0] {
    OFF_CTRL = 2'd0,
    OFF_STAT = 2'd1,
    OFF_SRC  = 2'd2,
    OFF_DST  = 2'd3
  } reg_off_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
  } trace_pair_t;
endpackage

// File: rtl/trace_hist_capture.sv
module trace_hist_capture
  import trace_hist_pkg::*;
(
  input  logic              en_i,
  input  logic              evt_vld_i,
  input  logic              evt_kind_i,
  input  logic [ADDR_W-1:0] br_src_i,
  input  logic [ADDR_W-1:0] br_dst_i,
  input  logic [ADDR_W-1:0] exc_ret_i,
  input  logic [ADDR_W-1:0] exc_vec_i,
  output logic              cap_o,
  output trace_pair_t       cap_pair_o
);
  assign cap_o = en_i & evt_vld_i;

  // exceptions take the stacked return value as source
  always_comb begin
    if (evt_kind_i == EVT_EXCEPT) begin
      cap_pair_o.src = exc_ret_i;
      cap_pair_o.dst = exc_vec_i;
    end else begin
      cap_pair_o.src = br_src_i;
      cap_pair_o.dst = br_dst_i;
    end
  end
endmodule

// File: rtl/trace_hist_queue.sv
module trace_hist_queue
  import trace_hist_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  trace_pair_t   cap_pair_i,
  input  logic          pop_i,
  input  logic          clr_i,
  output trace_pair_t   head_o,
  output logic          head_vld_o,
  output logic [CW-1:0] count_o
);
  trace_pair_t      pair_q [DEPTH];
  trace_pair_t      mid_p  [DEPTH];
  trace_pair_t      nxt_p  [DEPTH];
  logic [DEPTH-1:0] vld_q, mid_v, nxt_v;

  // stage 1: push at head, stage 2: pop from the pushed view
  always_comb begin
    mid_p[0] = cap_i ? cap_pair_i : pair_q[0];
    for (int i = 1; i < DEPTH; i++)
      mid_p[i] = cap_i ? pair_q[i-1] : pair_q[i];
    mid_v = cap_i ? {vld_q[DEPTH-2:0], 1'b1} : vld_q;

    for (int i = 0; i < DEPTH - 1; i++)
      nxt_p[i] = pop_i ? mid_p[i+1] : mid_p[i];
    nxt_p[DEPTH-1] = mid_p[DEPTH-1];
    nxt_v = pop_i ? {1'b0, mid_v[DEPTH-1:1]} : mid_v;
    if (clr_i) nxt_v = '0;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pair_q[g] <= '0;
      else         pair_q[g] <= nxt_p[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= nxt_v;
  end

  assign head_o     = pair_q[0];
  assign head_vld_o = vld_q[0];
  assign count_o    = CW'($countones(vld_q));

  a_r5_valid_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q & (vld_q + DEPTH'(1))) == '0);
  a_r3_capture_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i && !pop_i && !clr_i |=> head_o == $past(cap_pair_i) && head_vld_o);
  a_r7_pop_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !cap_i && !clr_i && count_o != 0 |=> count_o == $past(count_o) - 1'b1);
  a_r11_cap_pop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && cap_i && !clr_i && count_o == CW'(DEPTH) |=> count_o == CW'(DEPTH - 1));
  a_r2_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i && !pop_i && !clr_i |=> $stable(count_o) && $stable(head_o));
endmodule

// File: rtl/trace_hist_regs.sv
module trace_hist_regs
  import trace_hist_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_sel_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_off_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  trace_pair_t       head_i,
  input  logic              head_vld_i,
  input  logic [CW-1:0]     count_i,
  output logic              en_o,
  output logic              clr_o,
  output logic              pop_o,
  output logic [ADDR_W-1:0] reg_rdata_o
);
  logic en_q;
  logic ctrl_wr, rd;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i[ADDR_W-1:1];
  assign ctrl_wr = reg_sel_i & reg_we_i & (reg_off_i == OFF_CTRL);
  assign rd      = reg_sel_i & ~reg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (ctrl_wr) en_q <= reg_wdata_i[0];
  end

  assign en_o  = en_q;
  assign clr_o = ctrl_wr & reg_wdata_i[0] & ~en_q;   // off -> on only
  assign pop_o = rd & (reg_off_i == OFF_DST);

  always_comb begin
    reg_rdata_o = '0;
    if (rd) begin
      unique case (reg_off_i)
        OFF_CTRL: reg_rdata_o = ADDR_W'(en_q);
        OFF_STAT: reg_rdata_o = ADDR_W'(count_i);
        OFF_SRC:  reg_rdata_o = head_vld_i ? head_i.src : '0;
        OFF_DST:  reg_rdata_o = head_vld_i ? head_i.dst : '0;
        default:  reg_rdata_o = '0;
      endcase
    end
  end

  a_r10_enable_rise_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && reg_wdata_i[0] && !en_o |=> count_i == '0);
  a_r12_ctrl_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> en_o == $past(reg_wdata_i[0]));
  a_r12_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(en_o));
  a_r8_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && count_i == '0 && reg_off_i[1] |-> reg_rdata_o == '0);
endmodule

// File: rtl/trace_hist_top.sv
module trace_hist_top
  import trace_hist_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        evt_vld_i,
  input  logic        evt_kind_i,
  input  logic [31:0] br_src_i,
  input  logic [31:0] br_dst_i,
  input  logic [31:0] exc_ret_i,
  input  logic [31:0] exc_vec_i,
  input  logic        reg_sel_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_off_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o
);
  logic          en, cap, pop, clr, head_vld;
  trace_pair_t   cap_pair, head;
  logic [CW-1:0] count;

  trace_hist_capture u_cap (
    .en_i       (en),
    .evt_vld_i  (evt_vld_i),
    .evt_kind_i (evt_kind_i),
    .br_src_i   (br_src_i),
    .br_dst_i   (br_dst_i),
    .exc_ret_i  (exc_ret_i),
    .exc_vec_i  (exc_vec_i),
    .cap_o      (cap),
    .cap_pair_o (cap_pair)
  );

  trace_hist_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .cap_pair_i (cap_pair),
    .pop_i      (pop),
    .clr_i      (clr),
    .head_o     (head),
    .head_vld_o (head_vld),
    .count_o    (count)
  );

  trace_hist_regs #(.CW(CW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_sel_i   (reg_sel_i),
    .reg_we_i    (reg_we_i),
    .reg_off_i   (reg_off_i),
    .reg_wdata_i (reg_wdata_i),
    .head_i      (head),
    .head_vld_i  (head_vld),
    .count_i     (count),
    .en_o        (en),
    .clr_o       (clr),
    .pop_o       (pop),
    .reg_rdata_o (reg_rdata_o)
  );

  a_r2_off_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en && !pop && !clr |=> $stable(count));
  a_r6_src_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i && !reg_we_i && reg_off_i == OFF_SRC && !evt_vld_i && !clr
    |=> $stable(count) && $stable(head));
endmodule

// File: tb/trace_hist_top_test.sv
module trace_hist_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_vld = 1'b0, evt_kind = 1'b0;
  logic [31:0] br_src = '0, br_dst = '0, exc_ret = '0, exc_vec = '0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_off = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_hist_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_vld_i(evt_vld), .evt_kind_i(evt_kind),
    .br_src_i(br_src), .br_dst_i(br_dst),
    .exc_ret_i(exc_ret), .exc_vec_i(exc_vec),
    .reg_sel_i(reg_sel), .reg_we_i(reg_we), .reg_off_i(reg_off),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  task automatic check(input string req, input [31:0] act, input [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample read data, commit at posedge
  task automatic cyc(input logic ev, input logic kind, input [31:0] a, input [31:0] b,
                     input [31:0] c, input [31:0] d, input logic sel, input logic we,
                     input [1:0] off, input [31:0] wd, output [31:0] rd);
    @(negedge clk);
    evt_vld = ev; evt_kind = kind; br_src = a; br_dst = b; exc_ret = c; exc_vec = d;
    reg_sel = sel; reg_we = we; reg_off = off; reg_wdata = wd;
    #1 rd = reg_rdata;
    @(posedge clk);
    #1 evt_vld = 1'b0; reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic wr(input [1:0] off, input [31:0] wd);
    logic [31:0] rd;
    cyc(0, 0, 0, 0, 0, 0, 1, 1, off, wd, rd);
  endtask

  task automatic rdr(input [1:0] off, output [31:0] rd);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, off, 0, rd);
  endtask

  task automatic br_evt(input [31:0] s, input [31:0] d);
    logic [31:0] rd;
    cyc(1, 0, s, d, 32'hDEAD_0000, 32'hDEAD_0001, 0, 0, 0, 0, rd);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rdr(0, v); check("R1 ctrl", v, 0);
    rdr(1, v); check("R1 status", v, 0);
    rdr(2, v); check("R1 src", v, 0);
    rdr(3, v); check("R8 empty dst", v, 0);
    rdr(1, v); check("R8 empty pop no effect", v, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    do_reset();
    br_evt(32'h10, 32'h20);
    br_evt(32'h11, 32'h21);
    rdr(1, v); check("R2 count while off", v, 0);
    rdr(2, v); check("R2 src while off", v, 0);
  endtask

  task automatic t_branch();
    logic [31:0] v;
    do_reset();
    wr(0, 1);
    br_evt(32'h100, 32'h200);
    rdr(1, v); check("R9 count one", v, 1);
    rdr(2, v); check("R3 src", v, 32'h100);
    rdr(2, v); check("R6 src again", v, 32'h100);
    rdr(1, v); check("R6 no shift", v, 1);
    rdr(3, v); check("R3 dst", v, 32'h200);
    rdr(1, v); check("R7 popped", v, 0);
  endtask

  task automatic t_exc();
    logic [31:0] v;
    do_reset();
    wr(0, 1);
    cyc(1, 1, 32'h111, 32'h222, 32'h3004, 32'h80, 0, 0, 0, 0, v);
    rdr(2, v); check("R4 src stacked", v, 32'h3004);
    rdr(3, v); check("R4 dst handler", v, 32'h80);
  endtask

  task automatic t_fill();
    logic [31:0] v;
    do_reset();
    wr(0, 1);
    for (int k = 1; k <= 5; k++) br_evt(32'h1000 + k, 32'h2000 + k);
    rdr(1, v); check("R9 status full", v, 4);
    for (int k = 5; k >= 2; k--) begin
      rdr(2, v); check("R5 src order", v, 32'h1000 + k);
      rdr(3, v); check("R7 dst order", v, 32'h2000 + k);
    end
    rdr(1, v); check("R8 drained", v, 0);
    rdr(2, v); check("R8 src empty", v, 0);
  endtask

  task automatic t_toggle();
    logic [31:0] v;
    do_reset();
    wr(0, 1);
    br_evt(32'h31, 32'h41);
    br_evt(32'h32, 32'h42);
    wr(0, 1);
    rdr(1, v); check("R10 rewrite one keeps", v, 2);
    wr(0, 0);
    rdr(1, v); check("R10 disable keeps", v, 2);
    rdr(2, v); check("R10 disable readable", v, 32'h32);
    wr(0, 1);
    rdr(1, v); check("R10 reenable clears", v, 0);
    rdr(2, v); check("R10 src invalid", v, 0);
  endtask

  task automatic t_simul();
    logic [31:0] v;
    do_reset();
    wr(0, 1);
    br_evt(32'h1001, 32'h2001);
    br_evt(32'h1002, 32'h2002);
    cyc(1, 0, 32'h1003, 32'h2003, 0, 0, 1, 0, 3, 0, v);
    check("R11 read old head", v, 32'h2002);
    rdr(1, v); check("R11 count partial", v, 2);
    rdr(2, v); check("R11 head partial", v, 32'h1002);
    br_evt(32'h1004, 32'h2004);
    br_evt(32'h1005, 32'h2005);
    cyc(1, 0, 32'h1006, 32'h2006, 0, 0, 1, 0, 3, 0, v);
    check("R11 read full head", v, 32'h2005);
    rdr(1, v); check("R11 count full", v, 3);
    rdr(2, v); check("R11 head full", v, 32'h1005);
  endtask

  task automatic t_ro_writes();
    logic [31:0] v;
    do_reset();
    wr(0, 1);
    br_evt(32'h55, 32'h66);
    wr(1, 32'hFFFF_FFFF);
    wr(2, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    rdr(1, v); check("R12 status ro", v, 1);
    rdr(2, v); check("R12 src ro", v, 32'h55);
    rdr(0, v); check("R12 ctrl one", v, 1);
    wr(0, 32'hFFFF_FFFE);
    rdr(0, v); check("R12 ctrl bit0 only", v, 0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_branch();
    t_exc();
    t_fill();
    t_toggle();
    t_simul();
    t_ro_writes();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule